// File: doc/BRIEF.md
# Wiper Register Command Executor

This block holds a set of 10-bit wiper position registers, two by default, and runs 4-bit commands against them. A serial front end decodes each chip-select frame into a command code, an address and a data field. When chip select returns high it raises a one-cycle execute pulse. It also raises a flag that tells whether the strobe carried a full frame or no clock edges at all.

The command set covers these operations:
- direct position write;
- saturating step up and step down;
- a halving rotate, in which the low bit wraps to the top;
- a doubling left shift that clamps at full scale;
- all-channel forms of each adjustment;
- reload of wiper registers from the nonvolatile words presented at an input;
- readback selection;
- requests to the nonvolatile store.

A strobe with no clock edges repeats the last adjustment command. This allows push-button style stepping without resending frames.

Top module: `wiper_cmd_exec`

## Requirements
- R1: After reset every wiper reads the midscale code 512, and `rb_load_o` and `st_req_o` are low.
- R2: Command 11 loads `data_i` into the addressed wiper. Address 0 selects channel 0 and address 1 selects channel 1. An address with no channel changes nothing.
- R3: Command 14 adds one to the addressed wiper and command 15 adds one to every wiper. A wiper at 1023 stays at 1023.
- R4: Command 6 subtracts one from the addressed wiper and command 7 subtracts one from every wiper. A wiper at 0 stays at 0.
- R5: Command 4 rotates the addressed wiper right by one and command 5 rotates every wiper. The old bit 0 becomes bit 9.
- R6: Command 12 shifts the addressed wiper left by one, filling bit 0 with zero, and command 13 does this for every wiper. When bit 9 was set, the result is 1023.
- R7: Adjustment commands (4, 5, 6, 7, 12, 13, 14, 15) give the same result whatever `data_i` holds.
- R8: An execute pulse with `full_frame_i` low repeats the most recent full-frame adjustment command with its address. A full frame with any other command forgets the remembered command. With nothing remembered, or after reset, such a pulse changes nothing.
- R9: Command 1 loads the addressed wiper from its word in `nv_words_i`. Command 8 loads every wiper from its word.
- R10: One cycle after the execute pulse, command 10 places the addressed wiper in `rb_data_o` and command 9 places the addressed nonvolatile word there. Either one pulses `rb_load_o` for one cycle.
- R11: Command 2 pulses `st_req_o` with `st_addr_o` set to the address and `st_data_o` set to the addressed wiper. Command 3 does the same with `st_data_o` set to `data_i`. Neither changes a wiper.
- R12: Wipers change only in the cycle after an execute pulse. Commands 0, 2, 3, 9 and 10 leave every wiper unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exec_i | input | 1 | One-cycle execute pulse at end of strobe |
| full_frame_i | input | 1 | Strobe carried a complete frame |
| cmd_i | input | 4 | Command code |
| addr_i | input | AW (4) | Register address |
| data_i | input | W (10) | Data field |
| nv_words_i | input | NUM_CH*W (20) | Stored words, channel c at bits c*W |
| wiper_o | output | NUM_CH*W (20) | Wiper values, channel c at bits c*W |
| rb_data_o | output | W (10) | Readback value |
| rb_load_o | output | 1 | Readback value updated |
| st_req_o | output | 1 | Store write request |
| st_addr_o | output | AW (4) | Store write address |
| st_data_o | output | W (10) | Store write data |

## Verification
The bench sweeps every one of the 1024 starting codes through each single-channel adjustment. A wrong saturation therefore shows up at the exact edge: a step up that wraps 1023 to 0, or a step down that wraps 0 to 1023. A shift that loses the clamp returns a truncated value for any code with bit 9 set. A rotate that drops the wrapped bit shows up on every odd code. Repeat strobes are tested after adjustments, after a clearing frame and from reset, which catches a design that repeats stale or non-adjustment commands. The bench also checks that a design routing the wrong word to readback or to a store request, or mixing up the channel addresses, shows the error.

// File: rtl/wcx_pkg.sv
package wcx_pkg;
  typedef enum logic [3:0] {
    CMD_NOP       = 4'd0,
    CMD_RECALL    = 4'd1,
    CMD_SAVE      = 4'd2,
    CMD_STORE_DAT = 4'd3,
    CMD_ROR       = 4'd4,
    CMD_ROR_ALL   = 4'd5,
    CMD_DEC       = 4'd6,
    CMD_DEC_ALL   = 4'd7,
    CMD_RCL_ALL   = 4'd8,
    CMD_RD_NV     = 4'd9,
    CMD_RD_WIPER  = 4'd10,
    CMD_WRITE     = 4'd11,
    CMD_SHL       = 4'd12,
    CMD_SHL_ALL   = 4'd13,
    CMD_INC       = 4'd14,
    CMD_INC_ALL   = 4'd15
  } cmd_e;

  typedef enum logic [2:0] {
    OP_HOLD, OP_LOAD, OP_RECALL, OP_INC, OP_DEC, OP_ROR, OP_SHL
  } op_e;

  function automatic logic is_adjust(input logic [3:0] c);
    case (cmd_e'(c))
      CMD_ROR, CMD_ROR_ALL, CMD_DEC, CMD_DEC_ALL,
      CMD_SHL, CMD_SHL_ALL, CMD_INC, CMD_INC_ALL: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic is_broadcast(input logic [3:0] c);
    case (cmd_e'(c))
      CMD_ROR_ALL, CMD_DEC_ALL, CMD_SHL_ALL, CMD_INC_ALL, CMD_RCL_ALL: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic op_e cmd_to_op(input logic [3:0] c);
    case (cmd_e'(c))
      CMD_WRITE:                 return OP_LOAD;
      CMD_RECALL, CMD_RCL_ALL:   return OP_RECALL;
      CMD_INC, CMD_INC_ALL:      return OP_INC;
      CMD_DEC, CMD_DEC_ALL:      return OP_DEC;
      CMD_ROR, CMD_ROR_ALL:      return OP_ROR;
      CMD_SHL, CMD_SHL_ALL:      return OP_SHL;
      default:                   return OP_HOLD;
    endcase
  endfunction
endpackage

// File: rtl/wcx_cmd_decode.sv
module wcx_cmd_decode
  import wcx_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int AW     = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          exec_i,
  input  logic          full_frame_i,
  input  logic [3:0]    cmd_i,
  input  logic [AW-1:0] addr_i,
  output logic          go_o,
  output logic [3:0]    ecmd_o,
  output logic [AW-1:0] eaddr_o,
  output logic          addr_ok_o,
  output op_e           ch_op_o [NUM_CH]
);
  logic          rep_vld_q;
  logic [3:0]    rep_cmd_q;
  logic [AW-1:0] rep_addr_q;

  // remembered adjustment command for bare strobes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rep_vld_q  <= 1'b0;
      rep_cmd_q  <= '0;
      rep_addr_q <= '0;
    end else if (exec_i && full_frame_i) begin
      rep_vld_q  <= is_adjust(cmd_i);
      rep_cmd_q  <= cmd_i;
      rep_addr_q <= addr_i;
    end
  end

  assign go_o    = exec_i && (full_frame_i || rep_vld_q);
  assign ecmd_o  = full_frame_i ? cmd_i  : rep_cmd_q;
  assign eaddr_o = full_frame_i ? addr_i : rep_addr_q;

  always_comb begin
    addr_ok_o = 1'b0;
    for (int c = 0; c < NUM_CH; c++)
      if (eaddr_o == AW'(c)) addr_ok_o = 1'b1;
  end

  op_e base_op;
  logic bcast;
  assign base_op = cmd_to_op(ecmd_o);
  assign bcast   = is_broadcast(ecmd_o);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_op
    logic hit;
    assign hit = bcast || (eaddr_o == AW'(g));
    assign ch_op_o[g] = (go_o && hit) ? base_op : OP_HOLD;
  end
endmodule

// File: rtl/wcx_wiper_slice.sv
module wcx_wiper_slice
  import wcx_pkg::*;
#(
  parameter int W        = 10,
  parameter int RST_CODE = 512
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  op_e          op_i,
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] nv_i,
  output logic [W-1:0] wiper_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  logic [W-1:0] cur_q, nxt;

  always_comb begin
    nxt = cur_q;
    case (op_i)
      OP_LOAD:   nxt = data_i;
      OP_RECALL: nxt = nv_i;
      OP_INC:    nxt = (cur_q == MAX) ? MAX : cur_q + W'(1);
      OP_DEC:    nxt = (cur_q == '0) ? '0 : cur_q - W'(1);
      OP_ROR:    nxt = {cur_q[0], cur_q[W-1:1]};
      OP_SHL:    nxt = cur_q[W-1] ? MAX : {cur_q[W-2:0], 1'b0};
      default:   nxt = cur_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cur_q <= W'(RST_CODE);
    else         cur_q <= nxt;
  end

  assign wiper_o = cur_q;
endmodule

// File: rtl/wcx_xfer_port.sv
module wcx_xfer_port
  import wcx_pkg::*;
#(
  parameter int W      = 10,
  parameter int NUM_CH = 2,
  parameter int AW     = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                go_i,
  input  logic [3:0]          cmd_i,
  input  logic [AW-1:0]       addr_i,
  input  logic                addr_ok_i,
  input  logic [W-1:0]        data_i,
  input  logic [NUM_CH*W-1:0] wiper_i,
  input  logic [NUM_CH*W-1:0] nv_i,
  output logic [W-1:0]        rb_data_o,
  output logic                rb_load_o,
  output logic                st_req_o,
  output logic [AW-1:0]       st_addr_o,
  output logic [W-1:0]        st_data_o
);
  logic [W-1:0] sel_w, sel_nv;

  always_comb begin
    sel_w  = '0;
    sel_nv = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (addr_i == AW'(c)) begin
        sel_w  = wiper_i[c*W +: W];
        sel_nv = nv_i[c*W +: W];
      end
  end

  logic act;
  assign act = go_i && addr_ok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rb_data_o <= '0;
      rb_load_o <= 1'b0;
      st_req_o  <= 1'b0;
      st_addr_o <= '0;
      st_data_o <= '0;
    end else begin
      rb_load_o <= 1'b0;
      st_req_o  <= 1'b0;
      if (act) begin
        case (cmd_e'(cmd_i))
          CMD_RD_WIPER: begin rb_data_o <= sel_w;  rb_load_o <= 1'b1; end
          CMD_RD_NV:    begin rb_data_o <= sel_nv; rb_load_o <= 1'b1; end
          CMD_SAVE: begin
            st_req_o  <= 1'b1;
            st_addr_o <= addr_i;
            st_data_o <= sel_w;
          end
          CMD_STORE_DAT: begin
            st_req_o  <= 1'b1;
            st_addr_o <= addr_i;
            st_data_o <= data_i;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/wiper_cmd_exec.sv
module wiper_cmd_exec
  import wcx_pkg::*;
#(
  parameter int W        = 10,
  parameter int NUM_CH   = 2,
  parameter int AW       = 4,
  parameter int RST_CODE = 1 << (W - 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                exec_i,
  input  logic                full_frame_i,
  input  logic [3:0]          cmd_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [W-1:0]        data_i,
  input  logic [NUM_CH*W-1:0] nv_words_i,
  output logic [NUM_CH*W-1:0] wiper_o,
  output logic [W-1:0]        rb_data_o,
  output logic                rb_load_o,
  output logic                st_req_o,
  output logic [AW-1:0]       st_addr_o,
  output logic [W-1:0]        st_data_o
);
  logic          go;
  logic [3:0]    ecmd;
  logic [AW-1:0] eaddr;
  logic          addr_ok;
  op_e           ch_op [NUM_CH];

  wcx_cmd_decode #(.NUM_CH(NUM_CH), .AW(AW)) u_dec (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .exec_i       (exec_i),
    .full_frame_i (full_frame_i),
    .cmd_i        (cmd_i),
    .addr_i       (addr_i),
    .go_o         (go),
    .ecmd_o       (ecmd),
    .eaddr_o      (eaddr),
    .addr_ok_o    (addr_ok),
    .ch_op_o      (ch_op)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    wcx_wiper_slice #(.W(W), .RST_CODE(RST_CODE)) u_slice (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .op_i    (ch_op[g]),
      .data_i  (data_i),
      .nv_i    (nv_words_i[g*W +: W]),
      .wiper_o (wiper_o[g*W +: W])
    );
  end

  wcx_xfer_port #(.W(W), .NUM_CH(NUM_CH), .AW(AW)) u_xfer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .go_i      (go),
    .cmd_i     (ecmd),
    .addr_i    (eaddr),
    .addr_ok_i (addr_ok),
    .data_i    (data_i),
    .wiper_i   (wiper_o),
    .nv_i      (nv_words_i),
    .rb_data_o (rb_data_o),
    .rb_load_o (rb_load_o),
    .st_req_o  (st_req_o),
    .st_addr_o (st_addr_o),
    .st_data_o (st_data_o)
  );
endmodule

// File: rtl/wiper_cmd_exec_chk.sv
module wiper_cmd_exec_chk #(
  parameter int W      = 10,
  parameter int NUM_CH = 2,
  parameter int AW     = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                exec_i,
  input logic                full_frame_i,
  input logic [3:0]          cmd_i,
  input logic [AW-1:0]       addr_i,
  input logic [W-1:0]        data_i,
  input logic [NUM_CH*W-1:0] wiper_o,
  input logic                rb_load_o,
  input logic                st_req_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};
  logic [W-1:0] w0;
  assign w0 = wiper_o[W-1:0];

  logic ff0;
  assign ff0 = exec_i && full_frame_i && (addr_i == '0);

  // R12
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_i |=> $stable(wiper_o));

  // R2
  write_ch0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ff0 && cmd_i == 4'd11 |=> w0 == $past(data_i));

  // R3
  inc_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ff0 && cmd_i == 4'd14 |=> w0 == (($past(w0) == MAX) ? MAX : $past(w0) + W'(1)));

  // R4
  dec_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ff0 && cmd_i == 4'd6 && w0 == '0 |=> w0 == '0);

  // R12
  nop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_i && full_frame_i && cmd_i == 4'd0 |=> $stable(wiper_o));

  // R10
  rb_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rb_load_o |-> $past(exec_i));

  // R11
  st_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_req_o |-> $past(exec_i));
endmodule

bind wiper_cmd_exec wiper_cmd_exec_chk #(.W(W), .NUM_CH(NUM_CH), .AW(AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .exec_i       (exec_i),
  .full_frame_i (full_frame_i),
  .cmd_i        (cmd_i),
  .addr_i       (addr_i),
  .data_i       (data_i),
  .wiper_o      (wiper_o),
  .rb_load_o    (rb_load_o),
  .st_req_o     (st_req_o)
);

// File: tb/wiper_cmd_exec_tb.sv
`timescale 1ns/1ps
module wiper_cmd_exec_tb;
  localparam int W = 10, NC = 2, AW = 4;

  logic clk = 0, rst_n = 0;
  logic exec = 0, full = 0;
  logic [3:0] cmd = 0;
  logic [AW-1:0] addr = 0;
  logic [W-1:0] data = 0;
  logic [NC*W-1:0] nv = 0;
  logic [NC*W-1:0] wiper;
  logic [W-1:0] rb_data, st_data;
  logic rb_load, st_req;
  logic [AW-1:0] st_addr;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wiper_cmd_exec u_dut (
    .clk_i(clk), .rst_ni(rst_n), .exec_i(exec), .full_frame_i(full),
    .cmd_i(cmd), .addr_i(addr), .data_i(data), .nv_words_i(nv),
    .wiper_o(wiper), .rb_data_o(rb_data), .rb_load_o(rb_load),
    .st_req_o(st_req), .st_addr_o(st_addr), .st_data_o(st_data)
  );

  function automatic int wv(input int ch);
    return int'(wiper[ch*W +: W]);
  endfunction

  task automatic check(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic frame(input int c, input int a, input int d);
    @(negedge clk);
    exec = 1; full = 1; cmd = 4'(c); addr = AW'(a); data = W'(d);
    @(negedge clk);
    exec = 0; full = 0;
  endtask

  task automatic strobe();
    @(negedge clk);
    exec = 1; full = 0; cmd = 4'd11; addr = 4'd0; data = 10'h3FF;
    @(negedge clk);
    exec = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check(wv(0), 512, "R1 ch0 reset");
    check(wv(1), 512, "R1 ch1 reset");
    check(rb_load, 0, "R1 rb_load");
    check(st_req, 0, "R1 st_req");
    // R8: nothing remembered after reset
    strobe();
    check(wv(0), 512, "R8 bare strobe after reset");

    // R2
    frame(11, 0, 100);
    frame(11, 1, 900);
    check(wv(0), 100, "R2 ch0 write");
    check(wv(1), 900, "R2 ch1 write");
    frame(11, 3, 5);
    check(wv(0), 100, "R2 bad addr ch0");
    check(wv(1), 900, "R2 bad addr ch1");

    // R3 R4 R5 R6 sweeps over every start code
    for (int v = 0; v < 1024; v++) begin
      int d;
      d = v ^ 10'h2A5;
      frame(11, 0, v); frame(14, 0, d);
      check(wv(0), (v == 1023) ? 1023 : v + 1, "R3 inc");
      frame(11, 0, v); frame(6, 0, d);
      check(wv(0), (v == 0) ? 0 : v - 1, "R4 dec");
      frame(11, 0, v); frame(4, 0, d);
      check(wv(0), (v >> 1) | ((v & 1) << 9), "R5 ror");
      frame(11, 0, v); frame(12, 0, d);
      check(wv(0), (v >= 512) ? 1023 : v * 2, "R6 shl");
    end
    check(wv(1), 900, "R3 other channel untouched");

    // R7: data field varies, result the same
    frame(11, 1, 300); frame(14, 1, 0);
    check(wv(1), 301, "R7 inc data 0");
    frame(11, 1, 300); frame(14, 1, 1023);
    check(wv(1), 301, "R7 inc data 1023");

    // broadcast forms
    frame(11, 0, 1023); frame(11, 1, 0);
    frame(15, 0, 7);
    check(wv(0), 1023, "R3 inc all sat");
    check(wv(1), 1, "R3 inc all");
    frame(7, 0, 0);
    check(wv(0), 1022, "R4 dec all");
    check(wv(1), 0, "R4 dec all floor");
    frame(11, 0, 3); frame(11, 1, 2);
    frame(5, 0, 0);
    check(wv(0), 513, "R5 ror all wrap");
    check(wv(1), 1, "R5 ror all");
    frame(13, 0, 0);
    check(wv(0), 1023, "R6 shl all clamp");
    check(wv(1), 2, "R6 shl all");

    // R8 repeat
    frame(11, 0, 50); frame(11, 1, 10);
    frame(14, 1, 0);
    strobe(); strobe(); strobe();
    check(wv(1), 14, "R8 repeat inc");
    check(wv(0), 50, "R8 repeat keeps address");
    frame(0, 0, 0);
    strobe();
    check(wv(1), 14, "R8 cleared by nop");
    frame(6, 0, 0);
    strobe(); strobe();
    check(wv(0), 47, "R8 repeat dec");
    frame(11, 0, 20);
    strobe();
    check(wv(0), 20, "R8 cleared by write");
    frame(5, 0, 0);
    frame(11, 0, 4); frame(11, 1, 8);
    frame(5, 0, 0);
    strobe();
    check(wv(0), 1, "R8 repeat ror all ch0");
    check(wv(1), 2, "R8 repeat ror all ch1");

    // R9
    nv = {10'd333, 10'd777};
    frame(1, 1, 0);
    check(wv(1), 333, "R9 recall ch1");
    check(wv(0), 1, "R9 recall other untouched");
    frame(11, 0, 5); frame(11, 1, 6);
    frame(8, 0, 0);
    check(wv(0), 777, "R9 recall all ch0");
    check(wv(1), 333, "R9 recall all ch1");

    // R10
    frame(11, 1, 612);
    frame(10, 1, 0);
    check(rb_load, 1, "R10 rb_load wiper");
    check(rb_data, 612, "R10 rb wiper ch1");
    frame(9, 0, 0);
    check(rb_data, 777, "R10 rb nv ch0");
    @(negedge clk);
    check(rb_load, 0, "R10 rb_load one cycle");
    check(wv(1), 612, "R12 readback leaves wiper");

    // R11
    frame(2, 0, 99);
    check(st_req, 1, "R11 save req");
    check(st_addr, 0, "R11 save addr");
    check(st_data, 777, "R11 save data");
    frame(3, 1, 44);
    check(st_req, 1, "R11 store req");
    check(st_addr, 1, "R11 store addr");
    check(st_data, 44, "R11 store data");
    check(wv(1), 612, "R11 store leaves wiper");
    @(negedge clk);
    check(st_req, 0, "R11 req one cycle");

    // R12
    frame(0, 0, 123);
    check(wv(0), 777, "R12 nop ch0");
    @(negedge clk);
    cmd = 4'd11; addr = 0; data = 10'd9; full = 1;
    repeat (3) @(negedge clk);
    full = 0;
    check(wv(0), 777, "R12 no exec");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule